// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block holds the per-channel addressing state for a four-channel DMA engine. Each channel keeps a programmed (base) address and count and a working (current) copy of each. A processor-side register port programs the base values and the channel mode, sets the channel mask, and reads back the current values and a status word. A separate transfer sequencer, which owns bus arbitration and strobes, pulses a transfer strobe with a channel number for every data beat; the unit answers with that channel's address and then steps the address and count.

A channel finishes when a beat is made while its count is zero, so a programmed count N yields N+1 beats. On that final beat the unit raises a terminal-count pulse aligned with the address it presents, optionally an interrupt pulse, and either reloads the channel from its base copies (auto-initialize) or masks the channel. Terminal-count status flags stay set until the processor reads the status word.

Top module: `dma_cu_top`

## Requirements
- R1: After reset every channel is masked (mask word reads 4'hF), all base and current registers are zero, the status word reads zero and xfer_valid, tc_pulse and irq are low.
- R2: The register select cpu_addr is {kind[1:0], channel[1:0]}; kind 0 is address, 1 is count, 2 is mode (bit0 decrement, bit1 auto-initialize, bit2 interrupt enable), 3 is control (channel field 0: status, read only; 1: mask). Writing kind 0 or 1 loads both the base and the current copy; reads of kind 0 or 1 return the current copy and reads of mode return the mode; a read's value appears on cpu_rdata the cycle after cpu_rd.
- R3: A strobe on an unmasked channel makes xfer_valid high in the next cycle with xfer_addr equal to that channel's current address before the beat; without a strobe xfer_valid is low.
- R4: After a beat that is not the last of an auto-initializing channel, the current address moves by +1 (mode bit0 = 0) or -1 (bit0 = 1), wrapping modulo 2^16.
- R5: Each beat decrements the current count; a beat made while the count is zero is the last one, so count N gives N+1 beats, and tc_pulse is high in the same cycle as the last beat's xfer_valid.
- R6: With auto-initialize set, the last beat reloads both current registers from the base registers and leaves the mask bit clear.
- R7: Without auto-initialize, the last beat sets the channel's mask bit (mask word bit n = channel n, 1 = masked) and the current count becomes 16'hFFFF.
- R8: Every last beat sets the channel's terminal-count flag; the status word has the flags in bits [3:0], the request inputs sampled in the read cycle in bits [7:4], zeros above.
- R9: A status read returns the flags, then clears them; a flag set by a last beat in the same cycle as the read stays set.
- R10: irq pulses for one cycle together with tc_pulse when the finishing channel's interrupt enable is set, and stays low otherwise.
- R11: A strobe naming a masked channel is ignored: no xfer_valid, no tc_pulse, and that channel's registers are unchanged.
- R12: A processor write to a channel register in the same cycle as a beat on that channel takes precedence for the written register; a mask set by a last beat takes precedence over a mask write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register select {kind, channel} |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| req_in | input | 4 | Channel request levels, reported in status |
| xfer_stb | input | 1 | Transfer beat strobe from the sequencer |
| xfer_ch | input | 2 | Channel of the beat |
| xfer_valid | output | 1 | Beat accepted, address valid |
| xfer_addr | output | 16 | Address for the accepted beat |
| tc_pulse | output | 1 | Last beat of a channel's sequence |
| irq | output | 1 | Interrupt pulse on an enabled channel's end |

## Verification
The bound checker watches, every cycle, that an unmasked strobe always yields a beat and a masked one never does, that terminal count and interrupt only appear alongside a beat, and that terminal count always leaves a status flag set. The arithmetic of the sequence (N+1 beats, address stepping and wrap, reload on auto-initialize, masking at the end, clear-on-read racing a new terminal count, and write-versus-beat precedence) depends on programmed history and is shown only by the bench's directed scenarios and its randomized run against a reference model.

// File: rtl/dma_cu_pkg.sv
package dma_cu_pkg;

  typedef enum logic [1:0] {
    RK_ADDR  = 2'd0,
    RK_COUNT = 2'd1,
    RK_MODE  = 2'd2,
    RK_CTRL  = 2'd3
  } reg_kind_e;

  // bit0 decrement, bit1 auto-initialize, bit2 interrupt enable
  typedef struct packed {
    logic irq_en;
    logic auto_init;
    logic dec;
  } chan_mode_t;

  localparam int MODE_W = 3;

endpackage

// File: rtl/dma_cu_chan.sv
module dma_cu_chan
  import dma_cu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_mode,
  input  logic [ADDR_W-1:0] wdata_a,
  input  logic [CNT_W-1:0]  wdata_c,
  input  chan_mode_t        wdata_m,
  input  logic              beat,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output chan_mode_t        mode,
  output logic              last
);

  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] base_a;
  logic [CNT_W-1:0]  base_c;

  assign last = beat && (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a   <= '0;
      base_c   <= '0;
      cur_addr <= '0;
      cur_cnt  <= '0;
      mode     <= '0;
    end else begin
      if (beat) begin
        if (last && mode.auto_init) begin
          cur_addr <= base_a;
          cur_cnt  <= base_c;
        end else begin
          cur_addr <= mode.dec ? (cur_addr - A_ONE) : (cur_addr + A_ONE);
          cur_cnt  <= cur_cnt - C_ONE;
        end
      end
      // processor writes come last so they win over a same-cycle beat
      if (wr_addr) begin
        base_a   <= wdata_a;
        cur_addr <= wdata_a;
      end
      if (wr_cnt) begin
        base_c  <= wdata_c;
        cur_cnt <= wdata_c;
      end
      if (wr_mode) mode <= wdata_m;
    end
  end

endmodule

// File: rtl/dma_cu_status.sv
module dma_cu_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [NUM_CH-1:0] mask_wdata,
  input  logic              stat_rd,
  input  logic [NUM_CH-1:0] end_evt,
  input  logic [NUM_CH-1:0] auto_vec,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] tc_q
);

  logic [NUM_CH-1:0] mask_n;
  logic [NUM_CH-1:0] tc_n;

  always_comb begin
    mask_n = mask_q;
    tc_n   = tc_q;
    if (mask_wr) mask_n = mask_wdata;
    if (stat_rd) tc_n = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (end_evt[i]) begin
        tc_n[i] = 1'b1;
        if (!auto_vec[i]) mask_n[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      tc_q   <= '0;
    end else begin
      mask_q <= mask_n;
      tc_q   <= tc_n;
    end
  end

endmodule

// File: rtl/dma_cu_rdmux.sv
module dma_cu_rdmux
  import dma_cu_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int CHW    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd,
  input  reg_kind_e                     kind,
  input  logic [CHW-1:0]                ch,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] cur_addr_v,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cur_cnt_v,
  input  logic [NUM_CH-1:0][MODE_W-1:0] mode_v,
  input  logic [NUM_CH-1:0]             req,
  input  logic [NUM_CH-1:0]             tc,
  input  logic [NUM_CH-1:0]             mask,
  output logic [DATA_W-1:0]             rdata
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (kind)
      RK_ADDR:  sel[ADDR_W-1:0] = cur_addr_v[ch];
      RK_COUNT: sel[CNT_W-1:0]  = cur_cnt_v[ch];
      RK_MODE:  sel[MODE_W-1:0] = mode_v[ch];
      RK_CTRL: begin
        if (ch == CHW'(0)) begin
          sel[NUM_CH-1:0]        = tc;
          sel[2*NUM_CH-1:NUM_CH] = req;
        end else if (ch == CHW'(1)) begin
          sel[NUM_CH-1:0] = mask;
        end
      end
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= sel;
  end

endmodule

// File: rtl/dma_cu_top.sv
module dma_cu_top
  import dma_cu_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int CHW    = $clog2(NUM_CH),
  localparam int DATA_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [CHW+1:0]    cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [NUM_CH-1:0] req_in,
  input  logic              xfer_stb,
  input  logic [CHW-1:0]    xfer_ch,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              tc_pulse,
  output logic              irq
);

  reg_kind_e      kind;
  logic [CHW-1:0] rch;

  assign kind = reg_kind_e'(cpu_addr[CHW+1:CHW]);
  assign rch  = cpu_addr[CHW-1:0];

  logic [NUM_CH-1:0][ADDR_W-1:0] cur_addr_v;
  logic [NUM_CH-1:0][CNT_W-1:0]  cur_cnt_v;
  logic [NUM_CH-1:0][MODE_W-1:0] mode_v;
  logic [NUM_CH-1:0]             end_v;
  logic [NUM_CH-1:0]             auto_v;
  logic [NUM_CH-1:0]             ien_v;
  logic [NUM_CH-1:0]             mask_q;
  logic [NUM_CH-1:0]             tc_q;

  logic accept;
  logic stat_rd;
  logic mask_wr;

  assign accept  = xfer_stb && !mask_q[xfer_ch];
  assign stat_rd = cpu_rd && (kind == RK_CTRL) && (rch == CHW'(0));
  assign mask_wr = cpu_wr && (kind == RK_CTRL) && (rch == CHW'(1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chan_mode_t m;
    logic       sel_me;

    assign sel_me = (rch == CHW'(i));

    dma_cu_chan #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_addr (cpu_wr && sel_me && (kind == RK_ADDR)),
      .wr_cnt  (cpu_wr && sel_me && (kind == RK_COUNT)),
      .wr_mode (cpu_wr && sel_me && (kind == RK_MODE)),
      .wdata_a (cpu_wdata[ADDR_W-1:0]),
      .wdata_c (cpu_wdata[CNT_W-1:0]),
      .wdata_m (chan_mode_t'(cpu_wdata[MODE_W-1:0])),
      .beat    (accept && (xfer_ch == CHW'(i))),
      .cur_addr(cur_addr_v[i]),
      .cur_cnt (cur_cnt_v[i]),
      .mode    (m),
      .last    (end_v[i])
    );

    assign mode_v[i] = m;
    assign auto_v[i] = m.auto_init;
    assign ien_v[i]  = m.irq_en;
  end

  dma_cu_status #(
    .NUM_CH(NUM_CH)
  ) u_status (
    .clk       (clk),
    .rst       (rst),
    .mask_wr   (mask_wr),
    .mask_wdata(cpu_wdata[NUM_CH-1:0]),
    .stat_rd   (stat_rd),
    .end_evt   (end_v),
    .auto_vec  (auto_v),
    .mask_q    (mask_q),
    .tc_q      (tc_q)
  );

  dma_cu_rdmux #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .CHW   (CHW)
  ) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd        (cpu_rd),
    .kind      (kind),
    .ch        (rch),
    .cur_addr_v(cur_addr_v),
    .cur_cnt_v (cur_cnt_v),
    .mode_v    (mode_v),
    .req       (req_in),
    .tc        (tc_q),
    .mask      (mask_q),
    .rdata     (cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_valid <= 1'b0;
      xfer_addr  <= '0;
      tc_pulse   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      xfer_valid <= accept;
      tc_pulse   <= |end_v;
      irq        <= |(end_v & ien_v);
      if (accept) xfer_addr <= cur_addr_v[xfer_ch];
    end
  end

endmodule

// File: rtl/dma_cu_chk.sv
module dma_cu_chk #(
  parameter int NUM_CH = 4,
  localparam int CHW = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_stb,
  input logic [CHW-1:0]    xfer_ch,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] tc_q,
  input logic              xfer_valid,
  input logic              tc_pulse,
  input logic              irq
);

  AST_BEAT_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && !mask_q[xfer_ch]) |=> xfer_valid); // R3

  AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
    !xfer_stb |=> !xfer_valid); // R3

  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && mask_q[xfer_ch]) |=> (!xfer_valid && !tc_pulse)); // R11

  AST_TC_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> xfer_valid); // R5

  AST_IRQ_ON_TC: assert property (@(posedge clk) disable iff (rst)
    irq |-> tc_pulse); // R10

  AST_TC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (tc_q != '0)); // R8

endmodule

bind dma_cu_top dma_cu_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_stb  (xfer_stb),
  .xfer_ch   (xfer_ch),
  .mask_q    (mask_q),
  .tc_q      (tc_q),
  .xfer_valid(xfer_valid),
  .tc_pulse  (tc_pulse),
  .irq       (irq)
);

// File: tb/tb_dma_cu_top.sv
module tb_dma_cu_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        cpu_wr, cpu_rd;
  logic [3:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [3:0]  req_in;
  logic        xfer_stb;
  logic [1:0]  xfer_ch;
  logic        xfer_valid, tc_pulse, irq;
  logic [15:0] xfer_addr;

  dma_cu_top dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .req_in(req_in),
    .xfer_stb(xfer_stb), .xfer_ch(xfer_ch), .xfer_valid(xfer_valid),
    .xfer_addr(xfer_addr), .tc_pulse(tc_pulse), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
  logic [2:0]  m_md[4];
  logic [3:0]  m_msk, m_tc;

  // outputs sampled after each step
  logic        o_valid, o_tc, o_irq;
  logic [15:0] o_addr, o_rdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [3:0] a, input logic [3:0] rq);
    logic [1:0] c = a[1:0];
    case (a[3:2])
      2'd0: return m_ca[c];
      2'd1: return m_cc[c];
      2'd2: return {13'd0, m_md[c]};
      default: begin
        if (c == 2'd0) return {8'd0, rq, m_tc};
        if (c == 2'd1) return {12'd0, m_msk};
        return 16'd0;
      end
    endcase
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    if (a[3:2] != 2'd3) return "R2";
    if (a[1:0] == 2'd0) return "R8";
    return "R7";
  endfunction

  // one clock: drive at a falling edge, compare at the next falling edge
  task automatic step(input bit wr, input bit rd, input logic [3:0] a, input logic [15:0] wd,
                      input bit stb, input logic [1:0] ch, input logic [3:0] rq);
    bit acc, lst;
    logic [15:0] e_addr, e_rd;
    bit e_irq;
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = wd;
    xfer_stb = stb; xfer_ch = ch; req_in = rq;
    acc    = stb && !m_msk[ch];
    lst    = acc && (m_cc[ch] == 16'd0);
    e_addr = m_ca[ch];
    e_irq  = lst && m_md[ch][2];
    e_rd   = model_read(a, rq);
    // model update: beat, then status, then writes
    if (acc) begin
      if (lst && m_md[ch][1]) begin
        m_ca[ch] = m_ba[ch];
        m_cc[ch] = m_bc[ch];
      end else begin
        m_ca[ch] = m_md[ch][0] ? m_ca[ch] - 16'd1 : m_ca[ch] + 16'd1;
        m_cc[ch] = m_cc[ch] - 16'd1;
      end
    end
    if (rd && a == 4'hC) m_tc = 4'h0;
    if (wr && a == 4'hD) m_msk = wd[3:0];
    if (lst) begin
      m_tc[ch] = 1'b1;
      if (!m_md[ch][1]) m_msk[ch] = 1'b1;
    end
    if (wr) begin
      case (a[3:2])
        2'd0: begin m_ba[a[1:0]] = wd; m_ca[a[1:0]] = wd; end
        2'd1: begin m_bc[a[1:0]] = wd; m_cc[a[1:0]] = wd; end
        2'd2: m_md[a[1:0]] = wd[2:0];
        default: ;
      endcase
    end
    @(negedge clk);
    o_valid = xfer_valid; o_addr = xfer_addr; o_tc = tc_pulse;
    o_irq = irq; o_rdata = cpu_rdata;
    chk("R3 valid", {31'd0, o_valid}, {31'd0, acc});
    if (acc) chk("R3 addr", {16'd0, o_addr}, {16'd0, e_addr});
    chk("R5 tc", {31'd0, o_tc}, {31'd0, lst});
    chk("R10 irq", {31'd0, o_irq}, {31'd0, e_irq});
    if (rd) chk(read_tag(a), {16'd0, o_rdata}, {16'd0, e_rd});
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 2'd0, 4'h0);
  endtask

  task automatic rreg(input logic [3:0] a, input logic [3:0] rq);
    step(1'b0, 1'b1, a, 16'd0, 1'b0, 2'd0, rq);
  endtask

  task automatic beat(input logic [1:0] ch);
    step(1'b0, 1'b0, 4'h0, 16'd0, 1'b1, ch, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_md[i] = 0;
    end
    m_msk = 4'hF; m_tc = 4'h0;
    rst = 1'b1; cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
    req_in = 0; xfer_stb = 0; xfer_ch = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 valid", {31'd0, xfer_valid}, 32'd0);
    chk("R1 tc", {31'd0, tc_pulse}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rreg(4'hD, 4'h0); chk("R1 mask", {16'd0, o_rdata}, 32'h000F);
    rreg(4'hC, 4'h0); chk("R1 status", {16'd0, o_rdata}, 32'h0000);
    rreg(4'h2, 4'h0); chk("R1 cur addr", {16'd0, o_rdata}, 32'h0000);
    rreg(4'h5, 4'h0); chk("R1 cur count", {16'd0, o_rdata}, 32'h0000);
    beat(2'd0); chk("R1 masked after reset", {31'd0, o_valid}, 32'd0);

    // channel 0: count 2 gives three incrementing beats
    wreg(4'h0, 16'h1000); wreg(4'h4, 16'd2); wreg(4'h8, 16'd0); wreg(4'hD, 16'h0000);
    rreg(4'h0, 4'h0); chk("R2 current loaded", {16'd0, o_rdata}, 32'h1000);
    beat(2'd0); chk("R3 beat1", {16'd0, o_addr}, 32'h1000); chk("R5 no tc 1", {31'd0, o_tc}, 32'd0);
    beat(2'd0); chk("R4 beat2", {16'd0, o_addr}, 32'h1001); chk("R5 no tc 2", {31'd0, o_tc}, 32'd0);
    beat(2'd0); chk("R4 beat3", {16'd0, o_addr}, 32'h1002); chk("R5 tc on N+1", {31'd0, o_tc}, 32'd1);
    chk("R10 irq disabled", {31'd0, o_irq}, 32'd0);
    rreg(4'h4, 4'h0); chk("R7 count wrapped", {16'd0, o_rdata}, 32'hFFFF);
    rreg(4'hD, 4'h0); chk("R7 mask set", {16'd0, o_rdata}, 32'h0001);
    rreg(4'hC, 4'hA); chk("R8 status", {16'd0, o_rdata}, 32'h00A1);
    rreg(4'hC, 4'hA); chk("R9 cleared", {16'd0, o_rdata}, 32'h00A0);

    // channel 1: decrement through zero, interrupt enabled
    wreg(4'h1, 16'h0000); wreg(4'h5, 16'd0); wreg(4'h9, 16'h0005);
    beat(2'd1); chk("R10 irq", {31'd0, o_irq}, 32'd1); chk("R5 tc count0", {31'd0, o_tc}, 32'd1);
    rreg(4'h1, 4'h0); chk("R4 wrap down", {16'd0, o_rdata}, 32'hFFFF);

    // channel 2: auto-initialize
    wreg(4'h2, 16'h0020); wreg(4'h6, 16'd1); wreg(4'hA, 16'h0002);
    beat(2'd2); beat(2'd2); chk("R6 tc", {31'd0, o_tc}, 32'd1);
    beat(2'd2); chk("R6 reloaded", {16'd0, o_addr}, 32'h0020);
    rreg(4'hD, 4'h0); chk("R6 mask clear", {27'd0, o_rdata[4:0]}, 32'h0003);

    // masked strobe ignored
    wreg(4'hD, 16'h000F);
    beat(2'd2); chk("R11 no beat", {31'd0, o_valid}, 32'd0);
    rreg(4'h2, 4'h0); chk("R11 addr kept", {16'd0, o_rdata}, 32'h0021);
    rreg(4'h6, 4'h0); chk("R11 count kept", {16'd0, o_rdata}, 32'h0000);

    // status read racing a new terminal count on channel 3
    wreg(4'hD, 16'h0007); wreg(4'h3, 16'h0005); wreg(4'h7, 16'd0);
    step(1'b0, 1'b1, 4'hC, 16'd0, 1'b1, 2'd3, 4'h0);
    rreg(4'hC, 4'h0); chk("R9 race kept", {31'd0, o_rdata[3]}, 32'd1);

    // write versus beat on the same channel
    wreg(4'hD, 16'h0000); wreg(4'h3, 16'h0040); wreg(4'h7, 16'd3);
    step(1'b1, 1'b0, 4'h3, 16'h0080, 1'b1, 2'd3, 4'h0);
    rreg(4'h3, 4'h0); chk("R12 write wins", {16'd0, o_rdata}, 32'h0080);
    rreg(4'h7, 4'h0); chk("R12 count stepped", {16'd0, o_rdata}, 32'h0002);
    wreg(4'h7, 16'd0); wreg(4'hB, 16'd0);
    step(1'b1, 1'b0, 4'hD, 16'h0000, 1'b1, 2'd3, 4'h0);
    rreg(4'hD, 4'h0); chk("R12 end mask wins", {31'd0, o_rdata[3]}, 32'd1);

    // randomized traffic against the model
    for (int k = 0; k < 4000; k++) begin
      int op;
      logic [1:0] c;
      logic [3:0] rq;
      op = int'($urandom % 10);
      c  = 2'($urandom);
      rq = 4'($urandom);
      case (op)
        0, 1: step(1'b1, 1'b0, {2'd0, c}, 16'($urandom), 1'b0, 2'd0, rq);
        2:    step(1'b1, 1'b0, {2'd1, c}, 16'($urandom % 4), 1'b0, 2'd0, rq);
        3:    step(1'b1, 1'b0, {2'd2, c}, 16'($urandom % 8), 1'b0, 2'd0, rq);
        4:    step(1'b1, 1'b0, 4'hD, ($urandom % 2 == 0) ? 16'd0 : 16'($urandom % 16), 1'b0, 2'd0, rq);
        5:    step(1'b0, 1'b1, 4'($urandom % 14), 16'd0, 1'b0, 2'd0, rq);
        default: begin
          bit r = ($urandom % 4 == 0);
          bit w = ($urandom % 10 == 0);
          step(w, r, r ? 4'hC : {2'($urandom % 3), c}, 16'($urandom % 4), 1'b1, c, rq);
        end
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule